// File: doc/BRIEF.md
# Synchronized Multi-Channel Clock Divider Bank

This block takes one input clock, called the distribution clock, and produces a group of output channels from it. Each channel has an output mux. The mux passes either the undivided input clock (bypass) or the output of that channel's own even-integer divider, which has a 50% duty cycle. All configuration arrives on parallel inputs: the per-channel divide ratio, the bypass select and the enable bits.

An active-low sync input aligns the dividers. It enters through a two-flop synchronizer and then a short delay line, so entry and release each take exactly four distribution-clock cycles. While sync is active, every divided output is held low and each divider's ratio is reloaded. On release, all divided outputs rise on the same edge, and bypassed channels keep toggling throughout.

The output gating requires three things to be 1: a per-channel enable, a global enable bit and a global enable pin. A gated-off channel drives a constant 0, and its valid flag drops. Reset is asynchronous and active low. The system must release it synchronously to `clk`.

Top module: `clkdiv_bank`

## Requirements
- R1: While `rst_n` is low, every divided output is 0. With `sync_n` high, the divided outputs stay 0 after the first four `clk` edges that follow reset release, and all rise together on the fifth.
- R2: When `byp_sel[i]` is 1, an enabled channel `i` follows `clk` directly: it is high while `clk` is high and low while `clk` is low. When `byp_sel[i]` is 0, the channel carries its divider output.
- R3: A channel's ratio field holds the divide ratio D in bits `[i*DW +: DW]` of `div_ratio`. The effective half period is floor(D/2) cycles, and values 0 and 1 act as 2. After a release, the output is high for D/2 cycles, then low for D/2 cycles, repeating.
- R4: If `sync_n` is first sampled low on edge k, the divided outputs continue their pattern through edge k+3. From edge k+4 onward they are 0 for as long as `sync_n` stays low.
- R5: If `sync_n` is first sampled high on edge k after being low, the divided outputs are 0 through edge k+3. All divided outputs rise together on edge k+4.
- R6: Bypassed channels keep following `clk` while sync is active.
- R7: A change to a ratio field while the channel runs has no effect on its output. The new ratio takes effect at the next sync release.
- R8: `out_valid[i]` is 1 exactly when `ch_en[i]`, `glb_en_bit` and `glb_en_pin` are all 1. This is combinational from those inputs.
- R9: When `out_valid[i]` is 0, `clk_out[i]` is a constant 0, including for a bypassed channel.
- R10: Driving `glb_en_bit` or `glb_en_pin` low turns every channel off in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Distribution clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_n | input | 1 | Active-low divider alignment request (asynchronous) |
| glb_en_bit | input | 1 | Global output enable, configuration bit |
| glb_en_pin | input | 1 | Global output enable, pin |
| ch_en | input | NCH | Per-channel output enable |
| byp_sel | input | NCH | Per-channel mux select, 1 = bypass |
| div_ratio | input | NCH*DW | Packed per-channel divide ratios |
| clk_out | output | NCH | Channel outputs |
| out_valid | output | NCH | Per-channel active flag |

## Verification
On every cycle, the assertions check the following: the four-cycle relation between `sync_n` and the internal hold, the low outputs during hold, the common rise on release, the frozen ratio while running, and the all-off effect of the global controls. The bench scenarios cover the rest. These are the exact duty pattern for several ratios, including odd and sub-minimum values, the bypass path following both clock phases, and a ratio change that waits for the next release. The bench also checks the per-channel gating as seen at the ports.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // synchronizer flops ahead of the delay line
  localparam int SYNC_FLOPS   = 2;
  // total cycles from first sample of sync_n to divider reaction
  localparam int SYNC_LATENCY = 4;

  typedef enum logic {
    SRC_DIV = 1'b0,
    SRC_BYP = 1'b1
  } src_e;
endpackage

// File: rtl/clkdiv_sync_pipe.sv
module clkdiv_sync_pipe
  import clkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic hold
);
  localparam int DEPTH = SYNC_LATENCY;
  localparam int EXTRA = SYNC_LATENCY - SYNC_FLOPS;

  logic [DEPTH-1:0] pipe_q, pipe_d;

  // stage 0..SYNC_FLOPS-1 form the synchronizer, the EXTRA stages pad the latency
  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], sync_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign hold = ~pipe_q[DEPTH-1];

  initial begin
    if (EXTRA < 0) $error("sync latency shorter than synchronizer");
  end
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [DW-1:0] ratio,
  output logic          div_q
);
  localparam int HW = DW - 1;

  logic [HW-1:0] half_in, half_q;
  logic [HW-1:0] cnt_q, cnt_d;
  logic          q_q, q_d;
  logic          hold_q;
  logic          release_now;
  logic          half_load;

  // half period; ratios below 2 act as 2, odd ratios round down
  always_comb begin
    half_in = (ratio < DW'(2)) ? HW'(1) : HW'(ratio >> 1);
  end

  assign release_now = hold_q & ~hold;
  assign half_load   = hold;

  always_comb begin
    q_d   = q_q;
    cnt_d = cnt_q;
    if (hold) begin
      q_d   = 1'b0;
      cnt_d = '0;
    end else if (release_now) begin
      q_d   = 1'b1;
      cnt_d = '0;
    end else if (cnt_q == half_q - HW'(1)) begin
      q_d   = ~q_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= 1'b0;
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else begin
      q_q    <= q_d;
      cnt_q  <= cnt_d;
      hold_q <= hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         half_q <= HW'(1);
    else if (half_load) half_q <= half_in;
  end

  assign div_q = q_q;

  // R4: hold forces the divided output low on the next edge
  a_r4_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !div_q);

  // R5: the first cycle without hold makes the output rise
  a_r5_rise_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !hold) |=> div_q);

  // R7: the working ratio cannot change while the divider runs
  a_r7_ratio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> $stable(half_q));
endmodule

// File: rtl/clkdiv_out_gate.sv
module clkdiv_out_gate
  import clkdiv_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           glb_en_bit,
  input  logic           glb_en_pin,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] byp_sel,
  input  logic [NCH-1:0] div_q,
  output logic [NCH-1:0] clk_out,
  output logic [NCH-1:0] out_valid
);
  logic glb_on;
  assign glb_on = glb_en_bit & glb_en_pin;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    src_e src;
    logic muxed;
    assign src       = src_e'(byp_sel[i]);
    assign muxed     = (src == SRC_BYP) ? clk : div_q[i];
    assign out_valid[i] = ch_en[i] & glb_on;
    assign clk_out[i]   = out_valid[i] & muxed;
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int NCH = 4,
  parameter int DW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              glb_en_bit,
  input  logic              glb_en_pin,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH-1:0]    byp_sel,
  input  logic [NCH*DW-1:0] div_ratio,
  output logic [NCH-1:0]    clk_out,
  output logic [NCH-1:0]    out_valid
);
  import clkdiv_pkg::*;

  logic           hold;
  logic [NCH-1:0] div_q;

  clkdiv_sync_pipe u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_n (sync_n),
    .hold   (hold)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_div
    clkdiv_chan #(.DW(DW)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .ratio (div_ratio[i*DW +: DW]),
      .div_q (div_q[i])
    );
  end

  clkdiv_out_gate #(.NCH(NCH)) u_gate (
    .clk        (clk),
    .glb_en_bit (glb_en_bit),
    .glb_en_pin (glb_en_pin),
    .ch_en      (ch_en),
    .byp_sel    (byp_sel),
    .div_q      (div_q),
    .clk_out    (clk_out),
    .out_valid  (out_valid)
  );

  // edges since reset, saturating; lets the latency check look back safely
  logic [2:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        age_q <= '0;
    else if (age_q != 3'(SYNC_LATENCY)) age_q <= age_q + 3'd1;
  end

  // R4 and R5: hold reflects sync_n exactly four edges earlier
  a_r5_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'(SYNC_LATENCY)) |-> (hold == !$past(sync_n, 4)));

  // R10: either global control low turns every channel off
  a_r10_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en_bit || !glb_en_pin) |-> (out_valid == '0));
endmodule

// File: tb/test_clkdiv_bank.sv
module test_clkdiv_bank;
  localparam int NCH = 4;
  localparam int DW  = 6;

  logic              clk = 1'b0;
  logic              rst_n, sync_n, glb_en_bit, glb_en_pin;
  logic [NCH-1:0]    ch_en, byp_sel;
  logic [NCH*DW-1:0] div_ratio;
  logic [NCH-1:0]    clk_out, out_valid;

  int total = 0;
  int bad   = 0;
  int jcnt  = 0;
  int h1, h2, h3;

  always #4 clk = ~clk;

  clkdiv_bank #(.NCH(NCH), .DW(DW)) i_clkdiv_bank (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n),
    .glb_en_bit(glb_en_bit), .glb_en_pin(glb_en_pin),
    .ch_en(ch_en), .byp_sel(byp_sel), .div_ratio(div_ratio),
    .clk_out(clk_out), .out_valid(out_valid)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic phase(input int h, input int j);
    return ((j / h) % 2) == 0;
  endfunction

  function automatic logic [2:0] pat(input int j);
    return {phase(h3, j), phase(h2, j), phase(h1, j)};
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
    jcnt++;
  endtask

  task automatic set_ratio(input int ch, input int val);
    div_ratio[ch*DW +: DW] = DW'(val);
  endtask

  task automatic t_reset();
    chk("R1 reset div low", {1'b0, clk_out[3:1]}, 4'b0000);
    chk("R8 reset valid", out_valid, 4'b1111);
    @(posedge clk); #2;
    rst_n = 1'b1;
    for (int e = 1; e <= 4; e++) begin
      @(posedge clk); #2;
      chk("R1 low before rise", {1'b0, clk_out[3:1]}, 4'b0000);
    end
    @(posedge clk); #2;
    jcnt = 0;
    chk("R1 common rise", {1'b0, clk_out[3:1]}, 4'b0111);
  endtask

  task automatic t_pattern(input int n, input string req);
    for (int e = 0; e < n; e++) begin
      step();
      chk(req, {1'b0, clk_out[3:1]}, {1'b0, pat(jcnt)});
    end
  endtask

  task automatic t_bypass(input string req);
    chk(req, {3'b0, clk_out[0]}, 4'b0001);
    @(negedge clk); #2;
    chk(req, {3'b0, clk_out[0]}, 4'b0000);
  endtask

  task automatic t_ratio_frozen();
    set_ratio(2, 8);
    t_pattern(10, "R7 running ratio unchanged");
  endtask

  task automatic t_sync_entry();
    sync_n = 1'b0;
    t_pattern(4, "R4 pattern continues k..k+3");
    for (int e = 0; e < 6; e++) begin
      step();
      chk("R4 held low", {1'b0, clk_out[3:1]}, 4'b0000);
      t_bypass("R6 bypass during sync");
      step();
    end
  endtask

  task automatic t_sync_release();
    set_ratio(1, 0);
    set_ratio(3, 7);
    h1 = 1; h2 = 4; h3 = 3;
    sync_n = 1'b1;
    for (int e = 1; e <= 4; e++) begin
      step();
      chk("R5 low until k+4", {1'b0, clk_out[3:1]}, 4'b0000);
    end
    step();
    jcnt = 0;
    chk("R5 common rise", {1'b0, clk_out[3:1]}, 4'b0111);
    t_pattern(16, "R3 R7 new ratios after release");
  endtask

  task automatic t_enables();
    ch_en[2] = 1'b0;
    #1;
    chk("R8 channel valid", out_valid, 4'b1011);
    for (int e = 0; e < 4; e++) begin
      step();
      chk("R9 disabled channel zero", {3'b0, clk_out[2]}, 4'b0000);
    end
    ch_en[2] = 1'b1;
    glb_en_bit = 1'b0;
    #1;
    chk("R10 global bit off", out_valid, 4'b0000);
    chk("R9 all zero bit off", clk_out, 4'b0000);
    glb_en_bit = 1'b1;
    glb_en_pin = 1'b0;
    #1;
    chk("R10 global pin off", out_valid, 4'b0000);
    chk("R9 all zero pin off", clk_out, 4'b0000);
    glb_en_pin = 1'b1;
    #1;
    chk("R8 all back on", out_valid, 4'b1111);
  endtask

  initial begin
    #(8 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_n = 1'b1;
    glb_en_bit = 1'b1; glb_en_pin = 1'b1;
    ch_en = 4'b1111; byp_sel = 4'b0001;
    div_ratio = '0;
    set_ratio(0, 2); set_ratio(1, 2); set_ratio(2, 4); set_ratio(3, 6);
    h1 = 1; h2 = 2; h3 = 3;
    #13;
    t_reset();
    t_pattern(12, "R3 duty pattern");
    t_bypass("R2 bypass follows clk");
    step();
    chk("R2 divided path", {1'b0, clk_out[3:1]}, {1'b0, pat(jcnt)});
    t_ratio_frozen();
    t_sync_entry();
    t_sync_release();
    t_enables();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule